// File: doc/BRIEF.md
# ADC Trigger-to-Command Dispatcher

This block sits in front of an ADC conversion engine and decides when a conversion command starts. It has sixteen trigger slots. Each slot has one hardware trigger input and a small control register. The register holds a mode bit and a pointer into a table of fifteen conversion commands.

A slot in hardware mode fires on a rising edge of its input. A slot in software mode fires when software writes a 1 to that slot's trigger bit. A fired slot captures its command pointer and becomes pending. Pending slots are served lowest-numbered first. The served slot's pointer and slot number are offered to the engine on a valid/ready handshake.

A trigger that arrives at a slot which is still pending is not queued a second time. It sets a sticky overrun flag for that slot.

Top module: `adc_trig_dispatch`

## Requirements
- R1: After reset `cmd_valid_o` is low and every bit of `ovr_flag_o` is 0.
- R2: A control write (`ctl_we_i`) to slot `ctl_slot_i` stores mode bit `ctl_wdata_i[4]` (1 = hardware, 0 = software) and command pointer `ctl_wdata_i[3:0]`. A slot in software mode fires when `swt_we_i` is high and its bit in `swt_bits_i` is 1. The software bit acts as a one-shot request and needs no clearing. A slot in hardware mode ignores software trigger writes.
- R3: A slot in hardware mode fires once per rising edge of its `hw_trig_i` bit, after a two-flop synchroniser. A level held high does not fire the slot again. A slot in software mode ignores its hardware input.
- R4: A slot whose command pointer is 0 discards its triggers: no command is issued and no overrun is flagged. A command that is issued never carries pointer 0.
- R5: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o`, `cmd_index_o` and `cmd_slot_o` keep their values.
- R6: When several slots are pending, the lowest-numbered pending slot is issued first. `cmd_slot_o` gives that slot's number.
- R7: A trigger on a slot that is already pending, and is not being accepted in that cycle, sets that slot's bit in `ovr_flag_o`. The bit stays set until reset. The repeated trigger issues no extra command.
- R8: `cmd_index_o` carries the command pointer the slot held when it fired. Later control writes to that slot do not change it.
- R9: Each fired trigger is issued exactly once. In the cycle after a handshake (`cmd_valid_o` and `cmd_ready_i` both high), `cmd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_trig_i | input | 16 | Hardware trigger sources, one per slot, asynchronous |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_slot_i | input | 4 | Slot addressed by the control write |
| ctl_wdata_i | input | 5 | Bit 4: hardware mode; bits 3:0: command pointer |
| swt_we_i | input | 1 | Software trigger write strobe |
| swt_bits_i | input | 16 | Software trigger bits, 1 = fire the slot |
| cmd_valid_o | output | 1 | Command start request |
| cmd_index_o | output | 4 | Command pointer to execute (1 to 15) |
| cmd_slot_o | output | 4 | Number of the slot that fired |
| cmd_ready_i | input | 1 | Engine accepts the command |
| ovr_flag_o | output | 16 | Sticky per-slot overrun flags |

## Verification
The assertions watch the following on every cycle:
- the offered command stays stable under backpressure;
- an offered command never carries pointer 0;
- the offered slot is still marked pending;
- valid drops after every handshake;
- overrun flags never clear;
- a detected edge never lasts longer than one cycle.

Some behaviours are only visible through the bench's scenarios:
- serving order across slots;
- mode selection between hardware and software triggers;
- discarding of triggers on pointer 0;
- capture of the pointer at trigger time;
- the count of commands issued for a set of triggers.

The bench checks these against lists it builds from the slot configuration it wrote.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned NUM_SLOTS = 16;
  localparam int unsigned CMD_W     = 4;
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= async_i[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[i] = s2_q & ~s3_q;

    p_edge_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/slot_pend.sv
module slot_pend #(
  parameter int unsigned N     = 16,
  parameter int unsigned CMD_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              req_i,
  input  logic [N-1:0][CMD_W-1:0]   req_cmd_i,
  input  logic [N-1:0]              clr_i,
  output logic [N-1:0]              pend_o,
  output logic [N-1:0][CMD_W-1:0]   cmd_o,
  output logic [N-1:0]              ovr_o
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic busy_now;
    assign busy_now = pend_o[i] & ~clr_i[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[i] <= 1'b0;
        cmd_o[i]  <= '0;
        ovr_o[i]  <= 1'b0;
      end else begin
        if (req_i[i] && busy_now) begin
          ovr_o[i] <= 1'b1;  // keep the first request
        end else if (req_i[i]) begin
          pend_o[i] <= 1'b1;
          cmd_o[i]  <= req_cmd_i[i];
        end else if (clr_i[i]) begin
          pend_o[i] <= 1'b0;
        end
      end
    end

    p_ovr_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_o[i] |=> ovr_o[i]);
  end
endmodule

// File: rtl/lowest_first_arb.sv
module lowest_first_arb #(
  parameter int unsigned N    = 16,
  localparam int unsigned ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    pend_i,
  output logic            any_o,
  output logic [ID_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = ID_W'(i);
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/adc_trig_dispatch.sv
module adc_trig_dispatch
  import adc_trig_pkg::*;
#(
  parameter int unsigned N    = NUM_SLOTS,
  parameter int unsigned CW   = CMD_W,
  localparam int unsigned ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    hw_trig_i,
  input  logic            ctl_we_i,
  input  logic [ID_W-1:0] ctl_slot_i,
  input  logic [CW:0]     ctl_wdata_i,
  input  logic            swt_we_i,
  input  logic [N-1:0]    swt_bits_i,
  output logic            cmd_valid_o,
  output logic [CW-1:0]   cmd_index_o,
  output logic [ID_W-1:0] cmd_slot_o,
  input  logic            cmd_ready_i,
  output logic [N-1:0]    ovr_flag_o
);
  logic [N-1:0]          hw_en_q;
  logic [N-1:0][CW-1:0]  cmd_q;
  logic [N-1:0]          rise, sw_hit, req, clr, pend;
  logic [N-1:0][CW-1:0]  pend_cmd;
  logic                  any_pend;
  logic [ID_W-1:0]       arb_idx;
  logic                  busy_q, done;
  logic [ID_W-1:0]       gnt_id_q;
  logic [CW-1:0]         gnt_cmd_q;

  // control registers
  for (genvar i = 0; i < N; i++) begin : g_ctl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hw_en_q[i] <= 1'b0;
        cmd_q[i]   <= '0;
      end else if (ctl_we_i && ctl_slot_i == ID_W'(i)) begin
        hw_en_q[i] <= ctl_wdata_i[CW];
        cmd_q[i]   <= ctl_wdata_i[CW-1:0];
      end
    end
    // pointer 0 means no command: drop the trigger
    assign req[i] = (|cmd_q[i]) &
                    (hw_en_q[i] ? rise[i] : sw_hit[i]);
  end

  assign sw_hit = swt_we_i ? swt_bits_i : '0;

  trig_edge_det #(.N(N)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (hw_trig_i),
    .rise_o  (rise)
  );

  slot_pend #(.N(N), .CMD_W(CW)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .req_cmd_i (cmd_q),
    .clr_i     (clr),
    .pend_o    (pend),
    .cmd_o     (pend_cmd),
    .ovr_o     (ovr_flag_o)
  );

  lowest_first_arb #(.N(N)) u_arb (
    .pend_i (pend),
    .any_o  (any_pend),
    .idx_o  (arb_idx)
  );

  assign done = busy_q & cmd_ready_i;

  always_comb begin
    clr = '0;
    if (done) clr[gnt_id_q] = 1'b1;
  end

  // grant is frozen while offered so backpressure sees stable data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      gnt_id_q  <= '0;
      gnt_cmd_q <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (!busy_q && any_pend) begin
      busy_q    <= 1'b1;
      gnt_id_q  <= arb_idx;
      gnt_cmd_q <= pend_cmd[arb_idx];
    end
  end

  assign cmd_valid_o = busy_q;
  assign cmd_index_o = gnt_cmd_q;
  assign cmd_slot_o  = gnt_id_q;

  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=>
      cmd_valid_o && $stable(cmd_index_o) && $stable(cmd_slot_o));

  p_no_null_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_index_o != '0);

  p_offer_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> pend[cmd_slot_o]);

  p_drop_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> !cmd_valid_o);
endmodule

// File: tb/sim_adc_trig_dispatch.sv
module sim_adc_trig_dispatch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hw_trig = '0;
  logic        ctl_we = 1'b0;
  logic [3:0]  ctl_slot = '0;
  logic [4:0]  ctl_wdata = '0;
  logic        swt_we = 1'b0;
  logic [15:0] swt_bits = '0;
  logic        cmd_valid;
  logic [3:0]  cmd_index;
  logic [3:0]  cmd_slot;
  logic        cmd_ready = 1'b0;
  logic [15:0] ovr_flag;

  int total = 0;
  int bad = 0;

  logic        m_hw [16];
  logic [3:0]  m_cmd [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trig_dispatch u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .hw_trig_i   (hw_trig),
    .ctl_we_i    (ctl_we),
    .ctl_slot_i  (ctl_slot),
    .ctl_wdata_i (ctl_wdata),
    .swt_we_i    (swt_we),
    .swt_bits_i  (swt_bits),
    .cmd_valid_o (cmd_valid),
    .cmd_index_o (cmd_index),
    .cmd_slot_o  (cmd_slot),
    .cmd_ready_i (cmd_ready),
    .ovr_flag_o  (ovr_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr_ctl(input int slot, input bit hw, input int cmd);
    ctl_we = 1'b1; ctl_slot = 4'(slot); ctl_wdata = {hw, 4'(cmd)};
    m_hw[slot] = hw; m_cmd[slot] = 4'(cmd);
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic sw_fire(input logic [15:0] mask);
    swt_we = 1'b1; swt_bits = mask;
    tick();
    swt_we = 1'b0; swt_bits = '0;
  endtask

  task automatic wait_valid(input int max, output bit seen);
    seen = 0;
    for (int k = 0; k < max; k++) begin
      if (cmd_valid) begin seen = 1; break; end
      tick();
    end
  endtask

  // wait, check slot and pointer, hold ready low for a while, then accept
  task automatic expect_cmd(input string req, input int slot, input int cmd, input int hold);
    bit seen;
    wait_valid(12, seen);
    chk(seen, req, int'(cmd_valid), 1);
    if (!seen) return;
    chk(cmd_slot == 4'(slot), req, int'(cmd_slot), slot);
    chk(cmd_index == 4'(cmd), req, int'(cmd_index), cmd);
    for (int k = 0; k < hold; k++) begin
      tick();
      chk(cmd_valid && cmd_slot == 4'(slot) && cmd_index == 4'(cmd),
          "R5", int'(cmd_slot), slot);
    end
    cmd_ready = 1'b1;
    tick();
    cmd_ready = 1'b0;
    chk(!cmd_valid, "R9", int'(cmd_valid), 0);
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    bit any = 0;
    for (int k = 0; k < cycles; k++) begin
      if (cmd_valid) any = 1;
      tick();
    end
    chk(!any, req, int'(any), 0);
  endtask

  function automatic logic [15:0] served_mask(input logic [15:0] mask);
    logic [15:0] r = '0;
    for (int i = 0; i < 16; i++)
      r[i] = mask[i] && !m_hw[i] && m_cmd[i] != 0;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) begin m_hw[i] = 0; m_cmd[i] = 0; end
    tick(); tick();
    // R1
    chk(!cmd_valid, "R1", int'(cmd_valid), 0);
    chk(ovr_flag == 16'h0, "R1", int'(ovr_flag), 0);
    rst_n = 1'b1;
    tick();

    // R2: software fire
    wr_ctl(3, 0, 5);
    sw_fire(16'h0008);
    expect_cmd("R2", 3, 5, 3);
    expect_quiet("R9", 6);

    // R2: software write ignored in hardware mode
    wr_ctl(7, 1, 9);
    sw_fire(16'h0080);
    expect_quiet("R2", 10);

    // R3: hardware input ignored in software mode
    wr_ctl(1, 0, 4);
    hw_trig[1] = 1'b1; tick(); tick();
    expect_quiet("R3", 8);
    hw_trig[1] = 1'b0; tick(); tick(); tick();

    // R3: rising edge fires once, held level does not refire
    hw_trig[7] = 1'b1;
    expect_cmd("R3", 7, 9, 1);
    expect_quiet("R3", 10);
    hw_trig[7] = 1'b0;
    expect_quiet("R3", 5);

    // R4: pointer 0 discards
    wr_ctl(11, 0, 0);
    sw_fire(16'h0800);
    expect_quiet("R4", 8);
    chk(ovr_flag == 16'h0, "R4", int'(ovr_flag), 0);

    // R6: lowest slot first
    wr_ctl(2, 0, 1);
    wr_ctl(9, 0, 12);
    wr_ctl(14, 0, 15);
    sw_fire(16'h4204);
    expect_cmd("R6", 2, 1, 2);
    expect_cmd("R6", 9, 12, 0);
    expect_cmd("R6", 14, 15, 1);
    expect_quiet("R9", 6);

    // R8: pointer captured at trigger time
    wr_ctl(6, 0, 7);
    sw_fire(16'h0040);
    wr_ctl(6, 0, 2);
    expect_cmd("R8", 6, 7, 2);
    sw_fire(16'h0040);
    expect_cmd("R8", 6, 2, 0);

    // random software scenarios against computed order
    for (int it = 0; it < 40; it++) begin
      logic [15:0] mask, exp_m;
      for (int i = 0; i < 16; i++)
        wr_ctl(i, ($urandom % 4) == 0, $urandom % 16);
      mask  = 16'($urandom);
      exp_m = served_mask(mask);
      sw_fire(mask);
      for (int i = 0; i < 16; i++)
        if (exp_m[i]) expect_cmd("R6", i, int'(m_cmd[i]), $urandom % 4);
      expect_quiet("R9", 6);
    end
    chk(ovr_flag == 16'h0, "R7", int'(ovr_flag), 0);

    // R7: overrun on repeated trigger while pending
    wr_ctl(4, 0, 3);
    sw_fire(16'h0010);
    tick(); tick(); tick();
    sw_fire(16'h0010);
    tick();
    chk(ovr_flag == 16'h0010, "R7", int'(ovr_flag), 16'h0010);
    expect_cmd("R7", 4, 3, 1);
    expect_quiet("R7", 8);
    chk(ovr_flag == 16'h0010, "R7", int'(ovr_flag), 16'h0010);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule